// File: doc/BRIEF.md
# Fractional-Addend PTP Time Counter

This block keeps time of day for precision time protocol work. On every enabled core clock cycle it adds a programmable 32.32 fixed-point addend (whole nanoseconds above, fractions of a nanosecond below) to an internal accumulator. The whole-nanosecond part of the accumulator is the nanosecond count. When that count reaches a programmable rollover limit it subtracts the limit and keeps the excess, and a 32-bit seconds count steps by one. Software can trim the addend to track frequency error without disturbing the fraction already gathered.

A small register port lets software set the enable, the addend and the rollover limit, and read back the time. Reading the nanosecond field captures the seconds count in the same cycle, so that a later seconds read forms a coherent pair with it. Other logic in the chip takes the combined time on a 64-bit output.

Top module: `ptp_time_counter`

## Requirements
- R1: After a synchronous reset the time output is zero, the enable reads 0, the addend reads its reset value (default 0x0000_0001_0000_0000, 1.0 ns per cycle) and the captured seconds read 0.
- R2: While the enable bit is clear, the accumulator and the seconds count hold their values.
- R3: While enabled, each clock cycle adds the 64-bit addend (bits 63:32 whole nanoseconds, bits 31:0 fractions) to the 64-bit accumulator; the nanosecond count is the accumulator's upper 32 bits, and a 0.5 ns addend advances it once every two cycles.
- R4: The nanosecond count wraps in the cycle its sum reaches the limit (at exactly 1,000,000,000 with the default limit, never at 999,999,999) and is loaded with the sum minus the limit, not zero; the addend's whole part is assumed below the limit.
- R5: The seconds count steps by exactly one in each cycle the nanosecond count wraps, and at no other time.
- R6: The rollover limit is a writable register that resets to 1,000,000,000 and governs the wrap from the next cycle.
- R7: The time output carries seconds in bits 63:32 and nanoseconds in bits 31:0, both as held in the current cycle.
- R8: A read of the nanosecond field returns the nanoseconds of that cycle and captures the seconds of the same cycle; a read of the captured-seconds field returns that capture.
- R9: A write to the addend is used from the next clock cycle on, and the fraction already accumulated is kept.
- R10: Register map by address: 0 control (bit 0 enable), 1 addend (64 bits), 2 limit (bits 31:0), 3 nanoseconds (read only, bits 31:0), 4 captured seconds (read only, bits 31:0); writes to 3 to 7 are ignored and reads of 5 to 7 return zero; read data appears on the output one cycle after the read strobe and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid the cycle after the strobe |
| time_o | output | 64 | Seconds in 63:32, nanoseconds in 31:0 |

## Verification
Whole-nanosecond addends show plain counting, while 0.5 ns and random fractional addends separate a correct 32.32 carry from a design that drops or resets the fraction on a trim. Addends of 250, 333.33 and 300 million nanoseconds land the count exactly on, one short of and past the one-second limit, which tells a wrap at the right value with excess kept apart from an early wrap or a clear to zero. Small random limits with random enables, trims and reads make wraps frequent, so the seconds step, the hold while disabled and the captured-seconds pairing are exercised many times against a bench reference.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
    localparam int NS_W   = 32;
    localparam int FRAC_W = 32;
    localparam int SEC_W  = 32;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_ADDEND  = 3'd1,
        REG_LIMIT   = 3'd2,
        REG_NSEC    = 3'd3,
        REG_SECSNAP = 3'd4
    } reg_addr_e;

    localparam logic [NS_W-1:0] ONE_SEC_NS = 32'd1_000_000_000;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int                 ADD_W      = NS_W + FRAC_W,
    parameter logic [ADD_W-1:0]   ADDEND_RST = 64'h0000_0001_0000_0000,
    parameter logic [NS_W-1:0]    LIMIT_RST  = ONE_SEC_NS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NS_W-1:0]   ns_i,
    input  logic [SEC_W-1:0]  sec_i,
    output logic              en_o,
    output logic [ADD_W-1:0]  addend_o,
    output logic [NS_W-1:0]   limit_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic              en;
        logic [ADD_W-1:0]  addend;
        logic [NS_W-1:0]   limit;
        logic [SEC_W-1:0]  snap;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            case (reg_addr_e'(addr_i))
                REG_CTRL:    st_d.rdata = DATA_W'(st_q.en);
                REG_ADDEND:  st_d.rdata = DATA_W'(st_q.addend);
                REG_LIMIT:   st_d.rdata = DATA_W'(st_q.limit);
                REG_NSEC: begin
                    st_d.rdata = DATA_W'(ns_i);
                    st_d.snap  = sec_i;
                end
                REG_SECSNAP: st_d.rdata = DATA_W'(st_q.snap);
                default:     st_d.rdata = '0;
            endcase
        end
        if (wr_en_i) begin
            case (reg_addr_e'(addr_i))
                REG_CTRL:   st_d.en     = wdata_i[0];
                REG_ADDEND: st_d.addend = wdata_i[ADD_W-1:0];
                REG_LIMIT:  st_d.limit  = wdata_i[NS_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.en     <= 1'b0;
            st_q.addend <= ADDEND_RST;
            st_q.limit  <= LIMIT_RST;
            st_q.snap   <= '0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign addend_o = st_q.addend;
    assign limit_o  = st_q.limit;
    assign rdata_o  = st_q.rdata;

    // R8: nanosecond read returns the count of the strobe cycle
    a_r8_nsec_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && addr_i == REG_NSEC) |=> rdata_o == DATA_W'($past(ns_i)));

    // R9: addend write visible on the next cycle
    a_r9_addend_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == REG_ADDEND) |=> addend_o == $past(wdata_i[ADD_W-1:0]));
endmodule

// File: rtl/ptp_tc_nsec.sv
module ptp_tc_nsec
    import ptp_tc_pkg::*;
#(
    parameter int ADD_W = NS_W + FRAC_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [ADD_W-1:0] addend_i,
    input  logic [NS_W-1:0]  limit_i,
    output logic [NS_W-1:0]  ns_o,
    output logic             carry_o
);
    localparam int SUM_W = NS_W + FRAC_W + 1;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } acc_t;

    acc_t             st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic [NS_W:0]    sum_ns;
    logic             wrap;

    always_comb begin
        sum    = {1'b0, st_q.ns, st_q.frac} + SUM_W'(addend_i);
        sum_ns = sum[SUM_W-1:FRAC_W];
        wrap   = en_i && (sum_ns >= {1'b0, limit_i});
        st_d   = st_q;
        if (en_i) begin
            st_d.frac = sum[FRAC_W-1:0];
            if (wrap) begin
                st_d.ns = NS_W'(sum_ns - {1'b0, limit_i});
            end else begin
                st_d.ns = sum_ns[NS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ns_o    = st_q.ns;
    assign carry_o = wrap;

    // R2: accumulator frozen while disabled
    a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(st_q));

    // R4: without a wrap the count never moves backwards
    a_r4_no_early_drop: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !carry_o) |=> ns_o >= $past(ns_o));
endmodule

// File: rtl/ptp_tc_sec.sv
module ptp_tc_sec
    import ptp_tc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             carry_i,
    output logic [SEC_W-1:0] sec_o
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } sec_t;

    sec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (carry_i) begin
            st_d.sec = st_q.sec + SEC_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;

    // R5: one step per wrap
    a_r5_step: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_i |=> sec_o == $past(sec_o) + SEC_W'(1));

    // R5: no step without a wrap
    a_r5_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !carry_i |=> $stable(sec_o));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter logic [NS_W+FRAC_W-1:0] ADDEND_RST = 64'h0000_0001_0000_0000,
    parameter logic [NS_W-1:0]        LIMIT_RST  = ONE_SEC_NS
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    wr_en_i,
    input  logic                    rd_en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [SEC_W+NS_W-1:0]   time_o
);
    localparam int ADD_W = NS_W + FRAC_W;

    logic             en;
    logic [ADD_W-1:0] addend;
    logic [NS_W-1:0]  limit;
    logic [NS_W-1:0]  ns;
    logic [SEC_W-1:0] sec;
    logic             carry;

    ptp_tc_regs #(
        .ADD_W      (ADD_W),
        .ADDEND_RST (ADDEND_RST),
        .LIMIT_RST  (LIMIT_RST)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .ns_i     (ns),
        .sec_i    (sec),
        .en_o     (en),
        .addend_o (addend),
        .limit_o  (limit),
        .rdata_o  (rdata_o)
    );

    ptp_tc_nsec #(
        .ADD_W (ADD_W)
    ) u_nsec (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en),
        .addend_i (addend),
        .limit_i  (limit),
        .ns_o     (ns),
        .carry_o  (carry)
    );

    ptp_tc_sec u_sec (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .carry_i (carry),
        .sec_o   (sec)
    );

    assign time_o = {sec, ns};
endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [2:0]  addr;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [63:0] time_v;

    int vectors = 0;
    int fails   = 0;

    // reference state
    logic        m_en;
    logic [63:0] m_add;
    logic [31:0] m_lim, m_ns, m_frac, m_sec, m_snap;
    logic [63:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_counter dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .time_o  (time_v)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 1'b0; m_add = 64'h0000_0001_0000_0000; m_lim = 32'd1_000_000_000;
        m_ns = '0; m_frac = '0; m_sec = '0; m_snap = '0; m_rdata = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [63:0] d, input string tag);
        logic [64:0] s;
        logic [32:0] sn;
        wr_en = wr; rd_en = rd; addr = a; wdata = d;
        if (rd) begin
            case (a)
                3'd0: m_rdata = {63'd0, m_en};
                3'd1: m_rdata = m_add;
                3'd2: m_rdata = {32'd0, m_lim};
                3'd3: begin m_rdata = {32'd0, m_ns}; m_snap = m_sec; end
                3'd4: m_rdata = {32'd0, m_snap};
                default: m_rdata = '0;
            endcase
        end
        if (m_en) begin
            s = {1'b0, m_ns, m_frac} + {1'b0, m_add};
            sn = s[64:32];
            m_frac = s[31:0];
            if (sn >= {1'b0, m_lim}) begin
                m_ns = 32'(sn - {1'b0, m_lim});
                m_sec = m_sec + 32'd1;
            end else begin
                m_ns = sn[31:0];
            end
        end
        if (wr) begin
            case (a)
                3'd0: m_en = d[0];
                3'd1: m_add = d;
                3'd2: m_lim = d[31:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        chk(time_v, {m_sec, m_ns}, tag);
        if (rd) chk(rdata, m_rdata, tag);
    endtask

    task automatic print_summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        print_summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state via port and register reads
        chk(time_v, 64'd0, "R1");
        cyc(0, 1, 3'd0, 0, "R1");
        cyc(0, 1, 3'd1, 0, "R1");
        cyc(0, 1, 3'd4, 0, "R1");
        cyc(0, 1, 3'd2, 0, "R6");

        // R2: disabled counter holds
        repeat (4) cyc(0, 0, 0, 0, "R2");

        // R10: enable via control bit 0, then 1.0 ns counting
        cyc(1, 0, 3'd0, 64'd1, "R10");
        repeat (5) cyc(0, 0, 0, 0, "R3");
        chk(time_v, 64'd5, "R3");

        // R9: 0.5 ns trim, fraction kept
        cyc(1, 0, 3'd1, 64'h0000_0000_8000_0000, "R9");
        repeat (6) cyc(0, 0, 0, 0, "R9");
        cyc(1, 0, 3'd1, 64'h0000_0001_8000_0000, "R9");
        repeat (4) cyc(0, 0, 0, 0, "R9");

        // R2: disable and hold
        cyc(1, 0, 3'd0, 64'd0, "R2");
        repeat (4) cyc(0, 0, 0, 0, "R2");

        // R4: exact landing on the limit
        do_reset();
        cyc(1, 0, 3'd1, {32'd250_000_000, 32'd0}, "R4");
        cyc(1, 0, 3'd0, 64'd1, "R4");
        repeat (4) cyc(0, 0, 0, 0, "R4");
        chk(time_v, {32'd1, 32'd0}, "R4");

        // R4: one short of the limit must not wrap
        do_reset();
        cyc(1, 0, 3'd1, {32'd333_333_333, 32'd0}, "R4");
        cyc(1, 0, 3'd0, 64'd1, "R4");
        repeat (3) cyc(0, 0, 0, 0, "R4");
        chk(time_v, {32'd0, 32'd999_999_999}, "R4");
        cyc(0, 0, 0, 0, "R4");
        chk(time_v, {32'd1, 32'd333_333_332}, "R4");

        // R4/R5: excess kept across the wrap
        do_reset();
        cyc(1, 0, 3'd1, {32'd300_000_000, 32'd0}, "R4");
        cyc(1, 0, 3'd0, 64'd1, "R4");
        repeat (4) cyc(0, 0, 0, 0, "R5");
        chk(time_v, {32'd1, 32'd200_000_000}, "R5");

        // R6: small limit
        cyc(1, 0, 3'd2, 64'd1000, "R6");
        cyc(1, 0, 3'd1, {32'd300, 32'd0}, "R6");
        repeat (8) cyc(0, 0, 0, 0, "R6");
        cyc(0, 1, 3'd2, 0, "R6");

        // R8: coherent capture
        cyc(0, 1, 3'd3, 0, "R8");
        repeat (3) cyc(0, 0, 0, 0, "R8");
        cyc(0, 1, 3'd4, 0, "R8");
        chk(rdata, {32'd0, m_snap}, "R8");

        // R7: field layout
        chk({32'd0, time_v[63:32]}, {32'd0, m_sec}, "R7");
        chk({32'd0, time_v[31:0]}, {32'd0, m_ns}, "R7");

        // R10: ignored writes, empty reads, held read data
        cyc(1, 0, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        cyc(1, 0, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        cyc(0, 1, 3'd6, 0, "R10");
        cyc(0, 1, 3'd1, 0, "R10");
        cyc(0, 0, 0, 0, "R10");
        chk(rdata, m_rdata, "R10");

        // R3: random trims, limits, enables and reads
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            op = $urandom % 10;
            case (op)
                0: cyc(1, 0, 3'd1, {24'd0, 8'($urandom), 32'($urandom)}, "R3");
                1: cyc(1, 0, 3'd2, 64'(512 + ($urandom % 2000)), "R3");
                2: cyc(1, 0, 3'd0, 64'(($urandom % 4) != 0), "R3");
                3, 4: cyc(0, 1, 3'($urandom), 0, "R3");
                default: cyc(0, 0, 0, 0, "R3");
            endcase
        end

        print_summary();
        $finish;
    end
endmodule